// File: doc/BRIEF.md
# Control-Flow Execution Monitor

This block is a trusted watchdog that sits beside an untrusted multi-cycle processor built around one shared bus. Each clock cycle it samples the processor's raw control lines (register loads, ALU operation, register and memory write strobes, bus drive enables and selects) as a vector of thirteen small fields. It also samples the opcode the processor decoded. A deterministic automaton inside the block tracks which micro-step of which instruction the processor should be in. In each step it compares the observed vector with the exact pattern stored for that step.

In the fetch step the decoded opcode chooses the next step: an add runs three checked steps, a load and a multiply run one each, and a no-op completes at once. When an observed vector matches its step's pattern, the instruction advances. When the last step of an instruction matches, the block pulses an instruction-complete output. Any other vector, or an opcode the automaton does not know, moves it into an absorbing fault state. Fault and halt are raised in the same cycle as the offending vector. The block treats a hostile alteration, a design error and a transient upset in the same way. The expected patterns sit in a small table that a write port can overwrite, and reset restores the built-in patterns.

Top module: `cfm_monitor`

## Requirements
- R1: While `rst` is high and in the first cycle after it, the automaton is in fetch, the programmed patterns are back at their defaults, and `flt_state` and `flt_vec` read 0. With a valid fetch vector applied, `fault` and `halt_req` are 0.
- R2: Field i of a vector occupies bits [2i+1:2i]. The default fetch pattern has field 10 = 1 and all other fields 0. In fetch, any other vector gives a fault.
- R3: Opcode 1 (add) leads to three steps with default patterns (fields 0..12) 0,2,1,0,0,0,1,1,0,0,0,0,0, then 0,0,0,1,1,0,0,0,0,0,0,0,0, then 0,1,0,1,0,1,0,0,0,0,0,0,0. `instr_done` is high in the cycle the third step matches.
- R4: Opcode 2 (load) leads to one step whose default pattern has fields 4 and 6 = 1. Opcode 3 (multiply) leads to one step whose default pattern has field 1 = 3 and field 3 = 1. `instr_done` is high when that step matches. Opcode 0 (no-op) raises `instr_done` in the fetch cycle itself and stays in fetch.
- R5: A mismatch in any checked step raises `fault` and `halt_req` combinationally in that same cycle.
- R6: Once the automaton has faulted, `fault` and `halt_req` stay high whatever the inputs, until a synchronous reset.
- R7: On the first mismatch, the state code is captured into `flt_state` (fetch 0, add steps 1/2/3, load 4, multiply 5). The offending vector is captured into `flt_vec`. Both hold until reset.
- R8: In fetch, an opcode other than 0..3 gives a fault, even when the vector matches.
- R9: `pgm_en` with `pgm_sel` 0..5 replaces that state's pattern from the next cycle on. A write with `pgm_sel` 6 or 7 changes no pattern.
- R10: `instr_done` is never high in a cycle in which `fault` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_vec | input | 26 | Observed control vector, 13 fields of 2 bits |
| opcode | input | 4 | Decoded opcode, used in fetch |
| pgm_en | input | 1 | Pattern table write strobe |
| pgm_sel | input | 3 | State code of the pattern to overwrite |
| pgm_vec | input | 26 | New expected pattern |
| fault | output | 1 | Deviation detected (now or earlier) |
| halt_req | output | 1 | Request to stop the processor |
| instr_done | output | 1 | Instruction completed; automaton returns to fetch |
| flt_state | output | 3 | State in which the first mismatch occurred |
| flt_vec | output | 26 | Vector that caused the first mismatch |

## Verification
A wrong automaton state shows at the ports within one cycle. The next vector is compared against the wrong step's pattern, so `fault` rises in that cycle, or `instr_done` appears or is missing one step early or late. A dropped fault state shows up as `fault` falling after a mismatch. A capture error shows as `flt_state` or `flt_vec` differing from the step and vector of the first bad cycle. The bench walks complete add, load, multiply and no-op sequences, corrupts one field in mid-add, and checks the reprogrammed and restored patterns.

// File: rtl/cfm_pkg.sv
package cfm_pkg;

    localparam int N_FIELD = 13;
    localparam int FIELD_W = 2;
    localparam int VEC_W   = N_FIELD * FIELD_W;
    localparam int ST_W    = 3;
    localparam int N_SLOT  = 6;
    localparam int OPC_W   = 4;

    typedef logic [VEC_W-1:0] ctl_vec_t;

    typedef enum logic [ST_W-1:0] {
        S_FETCH = 3'd0,
        S_ADD0  = 3'd1,
        S_ADD1  = 3'd2,
        S_ADD2  = 3'd3,
        S_LOAD0 = 3'd4,
        S_MULT0 = 3'd5,
        S_FAULT = 3'd7
    } mon_state_e;

    localparam logic [OPC_W-1:0] OPC_NOP  = 4'd0;
    localparam logic [OPC_W-1:0] OPC_ADD  = 4'd1;
    localparam logic [OPC_W-1:0] OPC_LOAD = 4'd2;
    localparam logic [OPC_W-1:0] OPC_MULT = 4'd3;

    typedef struct packed {
        mon_state_e nxt;
        logic       bad;
        logic       done;
    } step_res_t;

    function automatic ctl_vec_t put_field(ctl_vec_t v, int idx, int val);
        ctl_vec_t r;
        r = v;
        r[idx*FIELD_W +: FIELD_W] = FIELD_W'(val);
        return r;
    endfunction

    function automatic ctl_vec_t default_pattern(int slot);
        ctl_vec_t v;
        v = '0;
        case (slot)
            0: v = put_field(v, 10, 1);
            1: begin
                v = put_field(v, 1, 2); v = put_field(v, 2, 1);
                v = put_field(v, 6, 1); v = put_field(v, 7, 1);
            end
            2: begin
                v = put_field(v, 3, 1); v = put_field(v, 4, 1);
            end
            3: begin
                v = put_field(v, 1, 1); v = put_field(v, 3, 1);
                v = put_field(v, 5, 1);
            end
            4: begin
                v = put_field(v, 4, 1); v = put_field(v, 6, 1);
            end
            5: begin
                v = put_field(v, 1, 3); v = put_field(v, 3, 1);
            end
            default: v = '0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/cfm_pattern_table.sv
module cfm_pattern_table
    import cfm_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [ST_W-1:0]     wr_sel,
    input  ctl_vec_t            wr_vec,
    input  logic [ST_W-1:0]     rd_sel,
    output ctl_vec_t            rd_vec
);

    ctl_vec_t slot_q [N_SLOT];

    for (genvar g = 0; g < N_SLOT; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                slot_q[g] <= default_pattern(g);
            else if (wr_en && (wr_sel == ST_W'(g)))
                slot_q[g] <= wr_vec;
        end
    end

    always_comb begin
        rd_vec = '0;
        for (int i = 0; i < N_SLOT; i++)
            if (rd_sel == ST_W'(i))
                rd_vec = slot_q[i];
    end

endmodule

// File: rtl/cfm_step_check.sv
module cfm_step_check
    import cfm_pkg::*;
(
    input  mon_state_e          st,
    input  ctl_vec_t            obs_vec,
    input  ctl_vec_t            exp_vec,
    input  logic [OPC_W-1:0]    opcode,
    output step_res_t           res
);

    logic match;
    assign match = (obs_vec == exp_vec);

    always_comb begin
        res.nxt  = st;
        res.bad  = 1'b0;
        res.done = 1'b0;
        unique case (st)
            S_FETCH: begin
                if (!match) begin
                    res.bad = 1'b1;
                end else begin
                    case (opcode)
                        OPC_NOP:  res.done = 1'b1;
                        OPC_ADD:  res.nxt  = S_ADD0;
                        OPC_LOAD: res.nxt  = S_LOAD0;
                        OPC_MULT: res.nxt  = S_MULT0;
                        default:  res.bad  = 1'b1;
                    endcase
                end
            end
            S_ADD0: if (match) res.nxt = S_ADD1; else res.bad = 1'b1;
            S_ADD1: if (match) res.nxt = S_ADD2; else res.bad = 1'b1;
            S_ADD2, S_LOAD0, S_MULT0: begin
                if (match) begin
                    res.nxt  = S_FETCH;
                    res.done = 1'b1;
                end else begin
                    res.bad = 1'b1;
                end
            end
            S_FAULT: res.nxt = S_FAULT;
            default: res.bad = 1'b1;
        endcase
        if (res.bad) begin
            res.nxt  = S_FAULT;
            res.done = 1'b0;
        end
    end

endmodule

// File: rtl/cfm_seq.sv
module cfm_seq
    import cfm_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  step_res_t   res,
    input  ctl_vec_t    obs_vec,
    output mon_state_e  st_q,
    output logic [ST_W-1:0] cap_state,
    output ctl_vec_t    cap_vec
);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= S_FETCH;
            cap_state <= '0;
            cap_vec   <= '0;
        end else begin
            st_q <= res.nxt;
            if (res.bad && st_q != S_FAULT) begin
                cap_state <= st_q;
                cap_vec   <= obs_vec;
            end
        end
    end

endmodule

// File: rtl/cfm_monitor.sv
module cfm_monitor
    import cfm_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [VEC_W-1:0]    ctl_vec,
    input  logic [OPC_W-1:0]    opcode,
    input  logic                pgm_en,
    input  logic [ST_W-1:0]     pgm_sel,
    input  logic [VEC_W-1:0]    pgm_vec,
    output logic                fault,
    output logic                halt_req,
    output logic                instr_done,
    output logic [ST_W-1:0]     flt_state,
    output logic [VEC_W-1:0]    flt_vec
);

    mon_state_e st_q;
    ctl_vec_t   exp_vec;
    step_res_t  res;

    cfm_pattern_table u_tbl (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (pgm_en),
        .wr_sel (pgm_sel),
        .wr_vec (pgm_vec),
        .rd_sel (st_q),
        .rd_vec (exp_vec)
    );

    cfm_step_check u_chk (
        .st      (st_q),
        .obs_vec (ctl_vec),
        .exp_vec (exp_vec),
        .opcode  (opcode),
        .res     (res)
    );

    cfm_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .res       (res),
        .obs_vec   (ctl_vec),
        .st_q      (st_q),
        .cap_state (flt_state),
        .cap_vec   (flt_vec)
    );

    assign fault      = (st_q == S_FAULT) || res.bad;
    assign halt_req   = fault;
    assign instr_done = res.done;

endmodule

// File: rtl/cfm_monitor_chk.sv
module cfm_monitor_chk
    import cfm_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            fault,
    input  logic            halt_req,
    input  logic            instr_done,
    input  logic [ST_W-1:0] flt_state,
    input  ctl_vec_t        flt_vec,
    input  mon_state_e      st_q
);

    logic past_ok;
    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (rst)
        fault |=> fault);  // R6
    AST_HALT_WITH_FAULT: assert property (@(posedge clk) disable iff (rst)
        fault |=> halt_req);  // R5
    AST_CAPTURE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (past_ok && st_q == S_FAULT) |=> ($stable(flt_state) && $stable(flt_vec)));  // R7
    AST_DONE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        instr_done |-> !fault);  // R10
    AST_DONE_TO_FETCH: assert property (@(posedge clk) disable iff (rst)
        instr_done |=> (st_q == S_FETCH));  // R3

endmodule

bind cfm_monitor cfm_monitor_chk u_cfm_monitor_chk (
    .clk        (clk),
    .rst        (rst),
    .fault      (fault),
    .halt_req   (halt_req),
    .instr_done (instr_done),
    .flt_state  (flt_state),
    .flt_vec    (flt_vec),
    .st_q       (st_q)
);

// File: tb/cfm_monitor_bench.sv
module cfm_monitor_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [25:0] ctl_vec = '0;
    logic [3:0]  opcode = '0;
    logic        pgm_en = 1'b0;
    logic [2:0]  pgm_sel = '0;
    logic [25:0] pgm_vec = '0;
    logic        fault, halt_req, instr_done;
    logic [2:0]  flt_state;
    logic [25:0] flt_vec;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    cfm_monitor u_cfm_monitor (
        .clk(clk), .rst(rst), .ctl_vec(ctl_vec), .opcode(opcode),
        .pgm_en(pgm_en), .pgm_sel(pgm_sel), .pgm_vec(pgm_vec),
        .fault(fault), .halt_req(halt_req), .instr_done(instr_done),
        .flt_state(flt_state), .flt_vec(flt_vec)
    );

    function automatic logic [25:0] fld(logic [25:0] v, int i, int val);
        logic [25:0] r;
        r = v;
        r[2*i +: 2] = 2'(val);
        return r;
    endfunction

    // Patterns written from the requirements (R2, R3, R4).
    function automatic logic [25:0] pat(int k);
        logic [25:0] v;
        v = '0;
        case (k)
            0: v = fld(v, 10, 1);
            1: v = fld(fld(fld(fld(v, 1, 2), 2, 1), 6, 1), 7, 1);
            2: v = fld(fld(v, 3, 1), 4, 1);
            3: v = fld(fld(fld(v, 1, 1), 3, 1), 5, 1);
            4: v = fld(fld(v, 4, 1), 6, 1);
            5: v = fld(fld(v, 1, 3), 3, 1);
            default: v = '0;
        endcase
        return v;
    endfunction

    localparam logic [25:0] CORRUPT = 26'h10;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive at negedge, check combinational outputs, let posedge commit.
    task automatic step(logic [3:0] opc, logic [25:0] v, logic ef, logic ed, string req);
        @(negedge clk);
        opcode = opc; ctl_vec = v;
        #1;
        chk(req, {31'd0, fault}, {31'd0, ef});
        chk(req, {31'd0, halt_req}, {31'd0, ef});
        chk(req, {31'd0, instr_done}, {31'd0, ed});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; ctl_vec = pat(0); opcode = 4'd0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // row: opcode[9:6] kind[5:3] corrupt[2] exp_fault[1] exp_done[0]
    localparam int NROW = 14;
    localparam logic [9:0] ROWS [NROW] = '{
        {4'd1, 3'd0, 1'b0, 1'b0, 1'b0},
        {4'd0, 3'd1, 1'b0, 1'b0, 1'b0},
        {4'd0, 3'd2, 1'b0, 1'b0, 1'b0},
        {4'd0, 3'd3, 1'b0, 1'b0, 1'b1},
        {4'd0, 3'd0, 1'b0, 1'b0, 1'b1},
        {4'd2, 3'd0, 1'b0, 1'b0, 1'b0},
        {4'd0, 3'd4, 1'b0, 1'b0, 1'b1},
        {4'd3, 3'd0, 1'b0, 1'b0, 1'b0},
        {4'd0, 3'd5, 1'b0, 1'b0, 1'b1},
        {4'd1, 3'd0, 1'b0, 1'b0, 1'b0},
        {4'd0, 3'd1, 1'b0, 1'b0, 1'b0},
        {4'd0, 3'd2, 1'b1, 1'b1, 1'b0},
        {4'd0, 3'd3, 1'b0, 1'b1, 1'b0},
        {4'd0, 3'd0, 1'b0, 1'b1, 1'b0}
    };

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        do_reset();
        // R1: reset state
        #1;
        chk("R1 flt_state", {29'd0, flt_state}, 32'd0);
        chk("R1 flt_vec", {6'd0, flt_vec}, 32'd0);
        chk("R1 fault", {31'd0, fault}, 32'd0);

        // Table walk: R3 add, R4 load/mult/nop, R5 mid-add corruption, R6 sticky
        for (int i = 0; i < NROW; i++) begin
            logic [25:0] v;
            v = pat(int'(ROWS[i][5:3]));
            if (ROWS[i][2]) v = v ^ CORRUPT;
            step(ROWS[i][9:6], v, ROWS[i][1], ROWS[i][0], "R3/R4/R5/R6 table");
        end
        #1;
        chk("R7 flt_state", {29'd0, flt_state}, 32'd2);
        chk("R7 flt_vec", {6'd0, flt_vec}, {6'd0, pat(2) ^ CORRUPT});
        step(4'd0, pat(0), 1'b1, 1'b0, "R6 still faulted");

        // R8: unknown opcode in fetch
        do_reset();
        step(4'd9, pat(0), 1'b1, 1'b0, "R8 unknown opcode");
        #1;
        chk("R8 flt_state", {29'd0, flt_state}, 32'd0);

        // R2: wrong vector in fetch
        do_reset();
        step(4'd0, pat(1), 1'b1, 1'b0, "R2 fetch mismatch");

        // R9: reprogram add step 2 to the multiply pattern
        do_reset();
        @(negedge clk);
        pgm_en = 1'b1; pgm_sel = 3'd2; pgm_vec = pat(5); ctl_vec = pat(0); opcode = 4'd0;
        @(negedge clk);
        pgm_en = 1'b0;
        step(4'd1, pat(0), 1'b0, 1'b0, "R9 fetch");
        step(4'd0, pat(1), 1'b0, 1'b0, "R9 add0");
        step(4'd0, pat(5), 1'b0, 1'b0, "R9 new pattern accepted");
        step(4'd0, pat(3), 1'b0, 1'b1, "R9 add2");
        step(4'd1, pat(0), 1'b0, 1'b0, "R9 fetch");
        step(4'd0, pat(1), 1'b0, 1'b0, "R9 add0");
        step(4'd0, pat(2), 1'b1, 1'b0, "R9 old pattern rejected");

        // R1: reset restores defaults
        do_reset();
        step(4'd1, pat(0), 1'b0, 1'b0, "R1 fetch");
        step(4'd0, pat(1), 1'b0, 1'b0, "R1 add0");
        step(4'd0, pat(2), 1'b0, 1'b0, "R1 default restored");

        // R9: write to code 6 is ignored; fetch pattern unchanged
        do_reset();
        @(negedge clk);
        pgm_en = 1'b1; pgm_sel = 3'd6; pgm_vec = pat(1); ctl_vec = pat(0); opcode = 4'd0;
        @(negedge clk);
        pgm_en = 1'b0;
        step(4'd0, pat(0), 1'b0, 1'b1, "R9 ignored sel 6");
        @(negedge clk);
        pgm_en = 1'b1; pgm_sel = 3'd7; pgm_vec = pat(4);
        @(negedge clk);
        pgm_en = 1'b0;
        step(4'd2, pat(0), 1'b0, 1'b0, "R9 ignored sel 7");
        step(4'd0, pat(4), 1'b0, 1'b1, "R10 load done, no fault");

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule